// File: doc/BRIEF.md
# Processor Status Flag Register

This block holds the eight condition and control bits of a small processor core in one byte: global interrupt enable, transfer bit, half carry, sign, two's complement overflow, negative, zero and carry. The core's ALU presents its result, carry out, carry out of bit 3 and overflow indication on every cycle. The instruction decoder raises a per-flag update strobe for each arithmetic flag that the current operation is allowed to change. Flags whose strobe is low keep their value. The sign bit is never stored on its own. It always follows negative XOR overflow, whichever path last changed those two.

Dedicated commands set or clear the interrupt enable. A bit-store command copies a chosen bit of an operand into the transfer bit. A bit-load output returns the operand with the chosen bit replaced by the transfer bit. The whole byte can also be read and written through a byte-wide memory-mapped I/O port. An accepted I/O write wins over every other update in the same cycle. A write that would change the interrupt enable is held off with one wait cycle before it takes effect.

The interrupt enable is changed only by the set/clear commands and by I/O writes. Nothing in this block touches it on interrupt entry or return. The block masks the combined peripheral request with that bit to form the core's interrupt request.

Top module: `status_flag_reg`

## Requirements
- R1: After reset every bit of `flags_out` is 0, and `io_ready` is 1 while no write is pending.
- R2: While `io_rd` is 1 and `io_addr` equals 0x0F, `io_rdata` shows the register with bit 7 = I, 6 = T, 5 = H, 4 = S, 3 = V, 2 = N, 1 = Z, 0 = C. Otherwise `io_rdata` is 0.
- R3: An accepted `io_wr` to address 0x0F loads bits 7, 6, 5, 3, 2, 1 and 0 from `io_wdata` on the next clock edge. A write to any other address changes nothing.
- R4: When a write to 0x0F carries a bit 7 different from the current I, `io_ready` is 0 in its first cycle and nothing is loaded. If the write is held, `io_ready` is 1 in the next cycle and the write is accepted there. A write whose bit 7 equals I is accepted in its first cycle.
- R5: An accepted I/O write takes priority over ALU flag updates, set/clear commands and bit-store in the same cycle.
- R6: For each bit of `flag_upd`, taken as {H,V,N,Z,C} from bit 4 down to bit 0, a 1 loads that flag on the next edge. H loads `alu_half`, V loads `alu_ovf`, N loads the result's top bit, Z loads 1 exactly when the result is 0, and C loads `alu_cout`. A flag whose strobe is 0 keeps its value.
- R7: Bit 4 (S) of `flags_out` always equals bit 3 XOR bit 2, including after I/O writes, whatever `io_wdata[4]` was.
- R8: `cmd_sei` sets I and `cmd_cli` clears I on the next edge. When both are 1, clear wins.
- R9: I changes only through `cmd_sei`, `cmd_cli` or an accepted I/O write. ALU updates and bit-store leave it unchanged.
- R10: `cmd_bst` loads T with `bit_operand[bit_sel]` on the next edge.
- R11: `bld_result` equals `bit_operand` with bit `bit_sel` replaced by the current T. It changes combinationally with its inputs.
- R12: `irq_req` is 1 exactly when I is 1 and at least one bit of `periph_irq` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 6 | I/O address |
| io_wr | input | 1 | I/O write request |
| io_rd | input | 1 | I/O read request |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data |
| io_ready | output | 1 | 0 during the wait cycle of a write that changes I |
| alu_result | input | 8 | ALU result byte |
| alu_cout | input | 1 | ALU carry out |
| alu_half | input | 1 | ALU carry out of bit 3 |
| alu_ovf | input | 1 | ALU two's complement overflow |
| flag_upd | input | 5 | Update strobes {H,V,N,Z,C} |
| cmd_sei | input | 1 | Set interrupt enable |
| cmd_cli | input | 1 | Clear interrupt enable |
| cmd_bst | input | 1 | Bit store into T |
| bit_operand | input | 8 | Operand for bit store / bit load |
| bit_sel | input | 3 | Bit index for bit store / bit load |
| bld_result | output | 8 | Operand with selected bit replaced by T |
| periph_irq | input | 4 | Peripheral interrupt requests |
| irq_req | output | 1 | Masked global interrupt request |
| flags_out | output | 8 | Current register value |

## Verification
The ALU path is tried with a zero result and carry, with a negative overflowing result under partial strobes, and with all strobes low. These cases show whether each strobe gates only its own flag and whether S follows N and V. I/O writes are tried with I unchanged, with I flipped and held, and at a neighbouring address, which separates the wait cycle from the plain write and from decode errors. Writes that collide with commands and ALU updates show the priority. A long stretch of random mixed traffic, compared every cycle against a behavioural model, covers interleavings such as commands arriving during a pending wait cycle.

// File: rtl/sflag_pkg.sv
package sflag_pkg;

    localparam int FLAG_W = 8;
    localparam int UPD_W  = 5;

    // positions inside the flag_upd strobe vector
    localparam int UPD_H = 4;
    localparam int UPD_V = 3;
    localparam int UPD_N = 2;
    localparam int UPD_Z = 1;
    localparam int UPD_C = 0;

    // packed MSB first: gie is bit 7, cy is bit 0
    typedef struct packed {
        logic gie;
        logic tb;
        logic hc;
        logic sg;
        logic ov;
        logic ng;
        logic zr;
        logic cy;
    } flags_t;

    typedef struct packed {
        flags_t flags;
        logic   wait_pend;
    } state_t;

    localparam flags_t FLAGS_RST = '0;

    function automatic flags_t fix_sign(input flags_t f);
        flags_t r;
        r    = f;
        r.sg = f.ng ^ f.ov;
        return r;
    endfunction

endpackage

// File: rtl/sflag_alu_merge.sv
module sflag_alu_merge
    import sflag_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  flags_t            cur,
    input  logic [DATA_W-1:0] alu_result,
    input  logic              alu_cout,
    input  logic              alu_half,
    input  logic              alu_ovf,
    input  logic [UPD_W-1:0]  flag_upd,
    output flags_t            nxt
);
    localparam int MSB = DATA_W - 1;

    logic res_zero;
    logic res_neg;

    assign res_zero = (alu_result == '0);
    assign res_neg  = alu_result[MSB];

    always_comb begin
        flags_t f;
        f = cur;
        if (flag_upd[UPD_H]) f.hc = alu_half;
        if (flag_upd[UPD_V]) f.ov = alu_ovf;
        if (flag_upd[UPD_N]) f.ng = res_neg;
        if (flag_upd[UPD_Z]) f.zr = res_zero;
        if (flag_upd[UPD_C]) f.cy = alu_cout;
        nxt = fix_sign(f);
    end

endmodule

// File: rtl/sflag_io_port.sv
module sflag_io_port
    import sflag_pkg::*;
#(
    parameter int              ADDR_W   = 6,
    parameter logic [ADDR_W-1:0] REG_ADDR = 6'h0F
) (
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [FLAG_W-1:0] io_wdata,
    input  flags_t            cur,
    input  logic              wait_q,
    output logic              accept,
    output logic              wait_d,
    output logic              io_ready,
    output logic [FLAG_W-1:0] io_rdata,
    output flags_t            wr_flags
);
    logic hit;
    logic wr_hit;
    logic gie_flip;
    logic stall;

    assign hit      = (io_addr == REG_ADDR);
    assign wr_hit   = io_wr & hit;
    assign gie_flip = io_wdata[FLAG_W-1] ^ cur.gie;
    assign stall    = wr_hit & gie_flip & ~wait_q;

    assign io_ready = ~stall;
    assign accept   = wr_hit & ~stall;
    assign wait_d   = stall;
    assign io_rdata = (io_rd & hit) ? cur : '0;
    assign wr_flags = fix_sign(flags_t'(io_wdata));

endmodule

// File: rtl/sflag_bit_xfer.sv
module sflag_bit_xfer #(
    parameter int DATA_W = 8,
    localparam int SEL_W = $clog2(DATA_W)
) (
    input  logic              cmd_bst,
    input  logic [DATA_W-1:0] bit_operand,
    input  logic [SEL_W-1:0]  bit_sel,
    input  logic              t_cur,
    output logic              t_nxt,
    output logic [DATA_W-1:0] bld_result
);
    assign t_nxt = cmd_bst ? bit_operand[bit_sel] : t_cur;

    for (genvar b = 0; b < DATA_W; b++) begin : g_bld
        assign bld_result[b] = (bit_sel == SEL_W'(b)) ? t_cur : bit_operand[b];
    end

endmodule

// File: rtl/sflag_irq_gate.sv
module sflag_irq_gate #(
    parameter int NUM_IRQ = 4
) (
    input  logic               gie,
    input  logic [NUM_IRQ-1:0] periph_irq,
    output logic               irq_req
);
    logic [NUM_IRQ:0] any_chain;

    assign any_chain[0] = 1'b0;
    for (genvar k = 0; k < NUM_IRQ; k++) begin : g_or
        assign any_chain[k+1] = any_chain[k] | periph_irq[k];
    end

    assign irq_req = gie & any_chain[NUM_IRQ];

endmodule

// File: rtl/status_flag_reg.sv
module status_flag_reg
    import sflag_pkg::*;
#(
    parameter int              ADDR_W   = 6,
    parameter logic [ADDR_W-1:0] REG_ADDR = 6'h0F,
    parameter int              DATA_W   = 8,
    parameter int              NUM_IRQ  = 4,
    localparam int             SEL_W    = $clog2(DATA_W)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  io_addr,
    input  logic               io_wr,
    input  logic               io_rd,
    input  logic [7:0]         io_wdata,
    output logic [7:0]         io_rdata,
    output logic               io_ready,
    input  logic [DATA_W-1:0]  alu_result,
    input  logic               alu_cout,
    input  logic               alu_half,
    input  logic               alu_ovf,
    input  logic [4:0]         flag_upd,
    input  logic               cmd_sei,
    input  logic               cmd_cli,
    input  logic               cmd_bst,
    input  logic [DATA_W-1:0]  bit_operand,
    input  logic [SEL_W-1:0]   bit_sel,
    output logic [DATA_W-1:0]  bld_result,
    input  logic [NUM_IRQ-1:0] periph_irq,
    output logic               irq_req,
    output logic [7:0]         flags_out
);
    state_t st_d, st_q;
    flags_t alu_flags;
    flags_t wr_flags;
    logic   accept;
    logic   wait_d;
    logic   t_nxt;

    sflag_alu_merge #(.DATA_W(DATA_W)) u_alu (
        .cur        (st_q.flags),
        .alu_result (alu_result),
        .alu_cout   (alu_cout),
        .alu_half   (alu_half),
        .alu_ovf    (alu_ovf),
        .flag_upd   (flag_upd),
        .nxt        (alu_flags)
    );

    sflag_io_port #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_io (
        .io_addr  (io_addr),
        .io_wr    (io_wr),
        .io_rd    (io_rd),
        .io_wdata (io_wdata),
        .cur      (st_q.flags),
        .wait_q   (st_q.wait_pend),
        .accept   (accept),
        .wait_d   (wait_d),
        .io_ready (io_ready),
        .io_rdata (io_rdata),
        .wr_flags (wr_flags)
    );

    sflag_bit_xfer #(.DATA_W(DATA_W)) u_bit (
        .cmd_bst     (cmd_bst),
        .bit_operand (bit_operand),
        .bit_sel     (bit_sel),
        .t_cur       (st_q.flags.tb),
        .t_nxt       (t_nxt),
        .bld_result  (bld_result)
    );

    sflag_irq_gate #(.NUM_IRQ(NUM_IRQ)) u_irq (
        .gie        (st_q.flags.gie),
        .periph_irq (periph_irq),
        .irq_req    (irq_req)
    );

    always_comb begin
        st_d          = st_q;
        st_d.flags    = alu_flags;
        st_d.flags.tb = t_nxt;
        if (cmd_cli) begin
            st_d.flags.gie = 1'b0;
        end else if (cmd_sei) begin
            st_d.flags.gie = 1'b1;
        end
        if (accept) begin
            st_d.flags = wr_flags;
        end
        st_d.wait_pend = wait_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{flags: FLAGS_RST, wait_pend: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign flags_out = st_q.flags;

endmodule

// File: rtl/sflag_checker.sv
module sflag_checker #(
    parameter int              ADDR_W   = 6,
    parameter logic [ADDR_W-1:0] REG_ADDR = 6'h0F,
    parameter int              NUM_IRQ  = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic [ADDR_W-1:0]  io_addr,
    input logic               io_wr,
    input logic [7:0]         io_wdata,
    input logic               io_ready,
    input logic               cmd_sei,
    input logic               cmd_cli,
    input logic [NUM_IRQ-1:0] periph_irq,
    input logic               irq_req,
    input logic [7:0]         flags_out
);
    logic hit_wr;
    assign hit_wr = io_wr && (io_addr == REG_ADDR);

    AST_SIGN_DERIVED: assert property (@(posedge clk) disable iff (!rst_n)
        flags_out[4] == (flags_out[3] ^ flags_out[2])); // R7

    AST_WAIT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        !io_ready |=> io_ready); // R4

    AST_STALL_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (!io_ready && !cmd_sei && !cmd_cli) |=> $stable(flags_out[7])); // R4

    AST_GIE_SOURCES: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_sei && !cmd_cli && !(hit_wr && io_ready)) |=> $stable(flags_out[7])); // R9

    AST_SEI_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_sei && !cmd_cli && !hit_wr) |=> flags_out[7]); // R8

    AST_IO_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_wr && io_ready) |=> (flags_out[7:5] == $past(io_wdata[7:5]) &&
                                  flags_out[3:0] == $past(io_wdata[3:0]))); // R5

    AST_IRQ_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req == (flags_out[7] && (periph_irq != '0))); // R12

endmodule

bind status_flag_reg sflag_checker #(
    .ADDR_W   (ADDR_W),
    .REG_ADDR (REG_ADDR),
    .NUM_IRQ  (NUM_IRQ)
) u_sflag_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .io_addr    (io_addr),
    .io_wr      (io_wr),
    .io_wdata   (io_wdata),
    .io_ready   (io_ready),
    .cmd_sei    (cmd_sei),
    .cmd_cli    (cmd_cli),
    .periph_irq (periph_irq),
    .irq_req    (irq_req),
    .flags_out  (flags_out)
);

// File: tb/test_status_flag_reg.sv
module test_status_flag_reg;
    localparam int PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] io_addr = '0;
    logic       io_wr = 1'b0, io_rd = 1'b0;
    logic [7:0] io_wdata = '0, io_rdata;
    logic       io_ready;
    logic [7:0] alu_result = '0;
    logic       alu_cout = 1'b0, alu_half = 1'b0, alu_ovf = 1'b0;
    logic [4:0] flag_upd = '0;
    logic       cmd_sei = 1'b0, cmd_cli = 1'b0, cmd_bst = 1'b0;
    logic [7:0] bit_operand = '0, bld_result;
    logic [2:0] bit_sel = '0;
    logic [3:0] periph_irq = '0;
    logic       irq_req;
    logic [7:0] flags_out;

    int compared = 0;
    int mismatched = 0;
    logic [7:0] m = '0;
    bit mw = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    status_flag_reg i_status_flag_reg (.*);

    task automatic cmp(string tag, logic [7:0] act, logic [7:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic idle();
        io_wr = 0; io_rd = 0; io_addr = '0; io_wdata = '0;
        flag_upd = '0; cmd_sei = 0; cmd_cli = 0; cmd_bst = 0;
    endtask

    // inputs are set at a falling edge; this checks, clocks and checks again
    task automatic tick(string tag);
        bit hit, acc;
        logic [7:0] n, bexp;
        #1;
        hit = (io_addr == 6'h0F);
        acc = io_wr && hit && ((io_wdata[7] == m[7]) || mw);
        cmp("R4 io_ready", {7'b0, io_ready}, {7'b0, !(io_wr && hit && !acc)});
        cmp("R2 io_rdata", io_rdata, (io_rd && hit) ? m : 8'h00);
        bexp = bit_operand; bexp[bit_sel] = m[6];
        cmp("R11 bld_result", bld_result, bexp);
        cmp("R12 irq_req", {7'b0, irq_req}, {7'b0, m[7] && (periph_irq != 0)});
        n = m;
        if (flag_upd[4]) n[5] = alu_half;
        if (flag_upd[3]) n[3] = alu_ovf;
        if (flag_upd[2]) n[2] = alu_result[7];
        if (flag_upd[1]) n[1] = (alu_result == 0);
        if (flag_upd[0]) n[0] = alu_cout;
        if (cmd_bst) n[6] = bit_operand[bit_sel];
        if (cmd_cli) n[7] = 0; else if (cmd_sei) n[7] = 1;
        if (acc) n = io_wdata;
        n[4] = n[3] ^ n[2];
        mw = io_wr && hit && !acc;
        m = n;
        @(negedge clk);
        cmp(tag, flags_out, m);
    endtask

    task automatic iowr(logic [5:0] a, logic [7:0] d);
        idle(); io_wr = 1; io_addr = a; io_wdata = d;
    endtask

    initial begin
        #(PERIOD * 150000);
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        cmp("R1 reset flags", flags_out, 8'h00);
        cmp("R1 reset ready", {7'b0, io_ready}, 8'h01);

        // R3 R7: write with I unchanged, bogus S bit
        iowr(6'h0F, 8'b0011_1101); tick("R3 R7 io write");
        idle(); io_rd = 1; io_addr = 6'h0F; tick("R2 read");
        iowr(6'h0E, 8'hFF); tick("R3 other address ignored");
        iowr(6'h0F, 8'b1000_0000); tick("R4 wait cycle holds");
        tick("R4 write accepted");
        iowr(6'h0F, 8'b1110_0110); tick("R4 no wait when I same");

        // R6 ALU patterns
        idle(); alu_result = 8'h00; alu_cout = 1; alu_half = 1; alu_ovf = 0;
        flag_upd = 5'b11111; tick("R6 zero result all strobes");
        idle(); alu_result = 8'h80; alu_ovf = 1; alu_cout = 0; alu_half = 0;
        flag_upd = 5'b01100; tick("R6 R7 only V N");
        idle(); alu_result = 8'h01; flag_upd = 5'b00000; tick("R6 no strobes hold");

        // R8 R9
        idle(); cmd_cli = 1; tick("R8 cli");
        idle(); flag_upd = 5'b11111; tick("R9 alu leaves I");
        idle(); cmd_sei = 1; tick("R8 sei");
        idle(); cmd_sei = 1; cmd_cli = 1; tick("R8 both clear wins");

        // R10 R11
        idle(); cmd_bst = 1; bit_operand = 8'h08; bit_sel = 3; tick("R10 bst set");
        idle(); bit_operand = 8'h00; bit_sel = 5; tick("R11 bld");
        idle(); cmd_bst = 1; bit_operand = 8'hF7; bit_sel = 3; tick("R10 bst clear");

        // R12
        idle(); periph_irq = 4'b0100; tick("R12 masked");
        idle(); cmd_sei = 1; tick("R12 enable");
        idle(); tick("R12 request passes");

        // R5 collision: write keeps I=1, ALU and cli lose
        iowr(6'h0F, 8'b1000_0001); cmd_cli = 1; cmd_bst = 1; flag_upd = 5'b11111;
        tick("R5 io wins");

        // random mix
        for (int i = 0; i < 3000; i++) begin
            bit hold;
            hold = mw;
            if (!hold) begin
                io_wr = ($urandom_range(0, 3) == 0);
                io_addr = ($urandom_range(0, 4) == 0) ? 6'($urandom) : 6'h0F;
                io_wdata = 8'($urandom);
            end
            io_rd = 1'($urandom); alu_result = 8'($urandom);
            if ($urandom_range(0, 3) == 0) alu_result = 8'h00;
            alu_cout = 1'($urandom); alu_half = 1'($urandom); alu_ovf = 1'($urandom);
            flag_upd = 5'($urandom);
            cmd_sei = ($urandom_range(0, 7) == 0); cmd_cli = ($urandom_range(0, 7) == 0);
            cmd_bst = 1'($urandom); bit_operand = 8'($urandom); bit_sel = 3'($urandom);
            periph_irq = 4'($urandom);
            tick("R6 R7 R9 random");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule